// File: doc/BRIEF.md
# Sector ECC Syndrome Checker with Single-Bit Repair Pointer

This block compares two 24-bit Hamming-style parity codes for one data sector. One code is the copy stored in the flash spare area; the other is the code computed while the sector was read. The block interleaves the even and odd line/column parities of both codes into a common syndrome and counts its ones. It then returns one of three verdicts: clean, repairable single data-bit error, or unrecoverable. For a repairable error it also returns the byte and the bit that the caller must invert in its own sector buffer. The block holds no sector data.

Codes arrive one sector at a time on a valid/ready input. A page is a fixed number of sectors, four by default. An internal sector counter tags each result with its sector number and turns the in-sector byte offset into a page byte offset. Results leave on a valid/ready output through a single register stage.

Back-pressure follows these rules. `in_ready` is high when the result register is empty, or when the result it holds is being taken in the same cycle. A result stays valid and unchanged until `res_ready` is sampled high. A result accepted on one edge is presented from the next edge on.

Top module: `ecc_page_checker`

## Requirements
- R1: When the stored and computed codes are identical, the result shows `res_no_error` alone.
- R2: Code layout, per parity level m = 0..11. The even parity is at bit m for m < 8 and at bit 16+(m-8) for m >= 8. The odd parity is at bit 8+m for m < 8 and at bit 20+(m-8) for m >= 8. When exactly 12 of the 24 XOR-difference bits are set, the result shows `res_corrected` alone. The in-sector byte offset is the odd-parity differences of levels 11..3, most significant first. `res_fix_bit` is the odd-parity differences of levels 2..0.
- R3: `res_fix_offset` equals the sector number times 512 plus the in-sector byte offset. The sector number starts at 0 after reset and advances by one for each accepted code pair. After sector 3 it returns to 0, and `res_page_last` is high on the sector-3 result.
- R4: Any other count of differing bits (1, 11, 23 and all values except 0 and 12) shows `res_uncorrectable` alone, unless R5 applies.
- R5: A stored code of all ones paired with a computed code of all zeros is an erased sector and shows `res_no_error`.
- R6: While `res_valid` is high, exactly one of the three status outputs is high. While it is low, all three are low.
- R7: `res_fix_offset` and `res_fix_bit` are zero whenever `res_corrected` is low.
- R8: A pair accepted on a clock edge gives `res_valid` high from that edge on. While `res_valid` is high and `res_ready` is low, all result outputs hold and `in_ready` is low.
- R9: After reset, `res_valid` and all status outputs are low and `in_ready` is high.
- R10: `res_fix_strobe` is high exactly in a cycle where a repairable result is handed over (`res_valid`, `res_ready` and `res_corrected` all high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Code pair present |
| in_ready | output | 1 | Code pair will be taken at the next edge |
| in_stored_code | input | 24 | Code read from the spare area |
| in_calc_code | input | 24 | Code computed over the sector |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_no_error | output | 1 | Clean or erased sector |
| res_corrected | output | 1 | Single data-bit error, repair pointer valid |
| res_uncorrectable | output | 1 | Error that cannot be repaired |
| res_fix_offset | output | 11 | Page byte offset to repair |
| res_fix_bit | output | 3 | Bit index within that byte |
| res_sector | output | 2 | Sector number of this result |
| res_page_last | output | 1 | Result belongs to the last sector of the page |
| res_fix_strobe | output | 1 | Repair handed over this cycle |

## Verification
The bound assertions check the properties that hold on every cycle. One status is high whenever a result is valid and none otherwise. The repair pointer is zero outside a repairable verdict. A stalled result is frozen and blocks the input, and an accepted pair always shows up one edge later. Equal codes and the erased pattern always yield a clean verdict. The verdict for each particular difference count is shown only by the bench scenarios: counts of 1, 11, 12, 23 and 24, random difference masks, and single-bit errors at the first and last bit of a sector. The same applies to the exact repair pointer, the page offset across the sector wrap, and the strobe timing under random stalls.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

  typedef enum logic [1:0] {
    VERD_CLEAN = 2'd0,
    VERD_FIXED = 2'd1,
    VERD_FATAL = 2'd2
  } verdict_e;

endpackage

// File: rtl/ecc_syn_map.sv
// Interleaves even/odd parity differences of both codes into one syndrome.
// Syndrome bit 2m is the even-parity difference of level m, bit 2m+1 the odd.
module ecc_syn_map #(
  parameter int PAIRS = 12
) (
  input  logic [2*PAIRS-1:0] stored,
  input  logic [2*PAIRS-1:0] computed,
  output logic [2*PAIRS-1:0] syndrome,
  output logic [PAIRS-1:0]   odd_diff
);
  localparam int CODE_W  = 2 * PAIRS;
  localparam int HI_BITS = PAIRS - 8;

  logic [CODE_W-1:0] diff;
  assign diff = stored ^ computed;

  for (genvar m = 0; m < PAIRS; m++) begin : g_level
    localparam int EVEN_AT = (m < 8) ? m     : 16 + (m - 8);
    localparam int ODD_AT  = (m < 8) ? 8 + m : 16 + HI_BITS + (m - 8);
    assign syndrome[2*m]     = diff[EVEN_AT];
    assign syndrome[2*m + 1] = diff[ODD_AT];
    assign odd_diff[m]       = diff[ODD_AT];
  end
endmodule

// File: rtl/ecc_ones_count.sv
module ecc_ones_count #(
  parameter int W  = 24,
  parameter int CW = 5
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) count = count + CW'(vec[i]);
  end
endmodule

// File: rtl/ecc_verdict.sv
module ecc_verdict
  import ecc_chk_pkg::*;
#(
  parameter int PAIRS = 12,
  parameter int CW    = 5
) (
  input  logic [CW-1:0]    count,
  input  logic [PAIRS-1:0] odd_diff,
  input  logic             erased,
  output verdict_e         verdict,
  output logic [PAIRS-4:0] byte_off,
  output logic [2:0]       bit_idx
);
  always_comb begin
    if (count == '0)                  verdict = VERD_CLEAN;
    else if (count == CW'(PAIRS))     verdict = VERD_FIXED;
    else if (erased)                  verdict = VERD_CLEAN;
    else                              verdict = VERD_FATAL;
  end

  assign byte_off = odd_diff[PAIRS-1:3];
  assign bit_idx  = odd_diff[2:0];
endmodule

// File: rtl/ecc_page_checker.sv
module ecc_page_checker
  import ecc_chk_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int PAGE_SECTORS = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      in_valid,
  output logic                                      in_ready,
  input  logic [2*($clog2(SECTOR_BYTES)+3)-1:0]     in_stored_code,
  input  logic [2*($clog2(SECTOR_BYTES)+3)-1:0]     in_calc_code,
  output logic                                      res_valid,
  input  logic                                      res_ready,
  output logic                                      res_no_error,
  output logic                                      res_corrected,
  output logic                                      res_uncorrectable,
  output logic [$clog2(SECTOR_BYTES*PAGE_SECTORS)-1:0] res_fix_offset,
  output logic [2:0]                                res_fix_bit,
  output logic [((PAGE_SECTORS>1)?$clog2(PAGE_SECTORS):1)-1:0] res_sector,
  output logic                                      res_page_last,
  output logic                                      res_fix_strobe
);
  localparam int SECT_AW = $clog2(SECTOR_BYTES);
  localparam int PAIRS   = SECT_AW + 3;
  localparam int CODE_W  = 2 * PAIRS;
  localparam int CNT_W   = $clog2(CODE_W + 1);
  localparam int SEC_W   = (PAGE_SECTORS > 1) ? $clog2(PAGE_SECTORS) : 1;
  localparam int PAGE_AW = $clog2(SECTOR_BYTES * PAGE_SECTORS);

  logic [CODE_W-1:0] syndrome;
  logic [PAIRS-1:0]  odd_diff;
  logic [CNT_W-1:0]  ones;
  verdict_e          verdict;
  logic [SECT_AW-1:0] sect_off;
  logic [2:0]        bit_idx;
  logic              erased;

  ecc_syn_map #(.PAIRS(PAIRS)) u_map (
    .stored   (in_stored_code),
    .computed (in_calc_code),
    .syndrome (syndrome),
    .odd_diff (odd_diff)
  );

  ecc_ones_count #(.W(CODE_W), .CW(CNT_W)) u_count (
    .vec   (syndrome),
    .count (ones)
  );

  assign erased = (in_stored_code == '1) && (in_calc_code == '0);

  ecc_verdict #(.PAIRS(PAIRS), .CW(CNT_W)) u_verdict (
    .count    (ones),
    .odd_diff (odd_diff),
    .erased   (erased),
    .verdict  (verdict),
    .byte_off (sect_off),
    .bit_idx  (bit_idx)
  );

  // ---- sector sequencing and result stage ----
  logic [SEC_W-1:0]   sec_cnt;
  logic               sec_wrap;
  logic [PAGE_AW-1:0] page_off;
  logic               accept;

  logic               valid_q;
  verdict_e           verdict_q;
  logic [PAGE_AW-1:0] off_q;
  logic [2:0]         bit_q;
  logic [SEC_W-1:0]   sec_q;
  logic               last_q;

  assign sec_wrap = (sec_cnt == SEC_W'(PAGE_SECTORS - 1));
  assign page_off = PAGE_AW'(sec_cnt) * PAGE_AW'(SECTOR_BYTES) + PAGE_AW'(sect_off);
  assign in_ready = !valid_q || res_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      verdict_q <= VERD_CLEAN;
      off_q     <= '0;
      bit_q     <= '0;
      sec_q     <= '0;
      last_q    <= 1'b0;
      sec_cnt   <= '0;
    end else if (accept) begin
      valid_q   <= 1'b1;
      verdict_q <= verdict;
      off_q     <= (verdict == VERD_FIXED) ? page_off : '0;
      bit_q     <= (verdict == VERD_FIXED) ? bit_idx  : '0;
      sec_q     <= sec_cnt;
      last_q    <= sec_wrap;
      sec_cnt   <= sec_wrap ? '0 : sec_cnt + 1'b1;
    end else if (res_ready) begin
      valid_q   <= 1'b0;
      verdict_q <= VERD_CLEAN;
      off_q     <= '0;
      bit_q     <= '0;
      last_q    <= 1'b0;
    end
  end

  assign res_valid         = valid_q;
  assign res_no_error      = valid_q && (verdict_q == VERD_CLEAN);
  assign res_corrected     = valid_q && (verdict_q == VERD_FIXED);
  assign res_uncorrectable = valid_q && (verdict_q == VERD_FATAL);
  assign res_fix_offset    = off_q;
  assign res_fix_bit       = bit_q;
  assign res_sector        = sec_q;
  assign res_page_last     = last_q;
  assign res_fix_strobe    = res_corrected && res_ready;
endmodule

// File: rtl/ecc_page_checker_sva.sv
module ecc_page_checker_sva #(
  parameter int CODE_W   = 24,
  parameter int PAGE_AW  = 11,
  parameter int SEC_W    = 2,
  parameter int LAST_SEC = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [CODE_W-1:0]  in_stored_code,
  input logic [CODE_W-1:0]  in_calc_code,
  input logic               res_valid,
  input logic               res_ready,
  input logic               res_no_error,
  input logic               res_corrected,
  input logic               res_uncorrectable,
  input logic [PAGE_AW-1:0] res_fix_offset,
  input logic [2:0]         res_fix_bit,
  input logic [SEC_W-1:0]   res_sector,
  input logic               res_page_last,
  input logic               res_fix_strobe
);
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones({res_no_error, res_corrected, res_uncorrectable}) == 1); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_no_error && !res_corrected && !res_uncorrectable); // R6
  AST_POINTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_corrected |-> res_fix_offset == '0 && res_fix_bit == '0); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_no_error) && $stable(res_corrected)
      && $stable(res_uncorrectable) && $stable(res_fix_offset) && $stable(res_fix_bit)
      && $stable(res_sector) && $stable(res_page_last)); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !in_ready); // R8
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> res_valid); // R8
  AST_EQUAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_stored_code == in_calc_code |=> res_no_error); // R1
  AST_ERASED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_stored_code == '1 && in_calc_code == '0 |=> res_no_error); // R5
  AST_LAST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_page_last |-> res_valid && res_sector == SEC_W'(LAST_SEC)); // R3
  AST_STROBE_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    res_fix_strobe |-> res_corrected && res_ready); // R10
endmodule

bind ecc_page_checker ecc_page_checker_sva #(
  .CODE_W   (CODE_W),
  .PAGE_AW  (PAGE_AW),
  .SEC_W    (SEC_W),
  .LAST_SEC (PAGE_SECTORS - 1)
) u_sva (
  .clk               (clk),
  .rst_n             (rst_n),
  .in_valid          (in_valid),
  .in_ready          (in_ready),
  .in_stored_code    (in_stored_code),
  .in_calc_code      (in_calc_code),
  .res_valid         (res_valid),
  .res_ready         (res_ready),
  .res_no_error      (res_no_error),
  .res_corrected     (res_corrected),
  .res_uncorrectable (res_uncorrectable),
  .res_fix_offset    (res_fix_offset),
  .res_fix_bit       (res_fix_bit),
  .res_sector        (res_sector),
  .res_page_last     (res_page_last),
  .res_fix_strobe    (res_fix_strobe)
);

// File: tb/ecc_page_checker_test.sv
module ecc_page_checker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_stored_code = '0;
  logic [23:0] in_calc_code = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_no_error, res_corrected, res_uncorrectable;
  logic [10:0] res_fix_offset;
  logic [2:0]  res_fix_bit;
  logic [1:0]  res_sector;
  logic        res_page_last, res_fix_strobe;

  int checks = 0;
  int fails  = 0;
  int sec    = 0;
  bit done   = 0;

  ecc_page_checker uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_stored_code(in_stored_code), .in_calc_code(in_calc_code),
    .res_valid(res_valid), .res_ready(res_ready), .res_no_error(res_no_error),
    .res_corrected(res_corrected), .res_uncorrectable(res_uncorrectable),
    .res_fix_offset(res_fix_offset), .res_fix_bit(res_fix_bit),
    .res_sector(res_sector), .res_page_last(res_page_last),
    .res_fix_strobe(res_fix_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Layout from R2
  function automatic int even_at(int m); return (m < 8) ? m : 16 + (m - 8); endfunction
  function automatic int odd_at(int m);  return (m < 8) ? 8 + m : 20 + (m - 8); endfunction

  function automatic logic [23:0] single_flip(int addr);
    logic [23:0] d = '0;
    for (int m = 0; m < 12; m++) begin
      if (addr[m]) d[odd_at(m)] = 1'b1;
      else         d[even_at(m)] = 1'b1;
    end
    return d;
  endfunction

  function automatic logic [23:0] mask_of(int k);
    logic [23:0] msk = '0;
    while ($countones(msk) < k) msk[$urandom % 24] = 1'b1;
    return msk;
  endfunction

  // expected verdict: 0 clean, 1 fixed, 2 fatal
  task automatic expect_of(input logic [23:0] st, input logic [23:0] ca,
                           output int verd, output int off, output int bidx);
    logic [23:0] d = st ^ ca;
    int n = $countones(d);
    off = 0; bidx = 0;
    if (n == 0) verd = 0;
    else if (n == 12) begin
      verd = 1;
      for (int k = 0; k < 9; k++) off  |= int'(d[odd_at(k + 3)]) << k;
      for (int k = 0; k < 3; k++) bidx |= int'(d[odd_at(k)]) << k;
    end else if (st == 24'hFFFFFF && ca == 24'h0) verd = 0;
    else verd = 2;
  endtask

  task automatic check_result(input string req, input int verd, input int off, input int bidx);
    chk(res_valid == 1'b1, "R8", "res_valid", res_valid, 1);
    chk(res_no_error == (verd == 0), req, "no_error", res_no_error, verd == 0);
    chk(res_corrected == (verd == 1), req, "corrected", res_corrected, verd == 1);
    chk(res_uncorrectable == (verd == 2), req, "uncorrectable", res_uncorrectable, verd == 2);
    chk(res_fix_offset == ((verd == 1) ? sec * 512 + off : 0), (verd == 1) ? "R3" : "R7",
        "fix_offset", res_fix_offset, (verd == 1) ? sec * 512 + off : 0);
    chk(res_fix_bit == bidx, (verd == 1) ? "R2" : "R7", "fix_bit", res_fix_bit, bidx);
    chk(res_sector == sec, "R3", "sector", res_sector, sec);
    chk(res_page_last == (sec == 3), "R3", "page_last", res_page_last, sec == 3);
  endtask

  task automatic run(input logic [23:0] st, input logic [23:0] ca, input int stall, input string req);
    int verd, off, bidx;
    expect_of(st, ca, verd, off, bidx);
    @(negedge clk);
    in_valid = 1'b1; in_stored_code = st; in_calc_code = ca; res_ready = 1'b0;
    #1 chk(in_ready == 1'b1, "R8", "in_ready idle", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    #1 check_result(req, verd, off, bidx);
    for (int s = 0; s < stall; s++) begin
      chk(in_ready == 1'b0, "R8", "in_ready stalled", in_ready, 0);
      chk(res_fix_strobe == 1'b0, "R10", "strobe stalled", res_fix_strobe, 0);
      @(negedge clk);
      #1 check_result("R8", verd, off, bidx);
    end
    res_ready = 1'b1;
    #1 chk(res_fix_strobe == (verd == 1), "R10", "strobe", res_fix_strobe, verd == 1);
    chk(in_ready == 1'b1, "R8", "in_ready on take", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    #1 chk(res_valid == 1'b0, "R8", "valid after take", res_valid, 0);
    chk(res_corrected == 1'b0 && res_fix_offset == 0, "R7", "pointer idle", res_fix_offset, 0);
    sec = (sec + 1) % 4;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] st;
    void'($urandom(32'h1357ACE1));
    repeat (3) @(negedge clk);
    #1 chk(res_valid == 0, "R9", "valid in reset", res_valid, 0);
    chk({res_no_error, res_corrected, res_uncorrectable} == 0, "R9", "status in reset",
        {res_no_error, res_corrected, res_uncorrectable}, 0);
    chk(in_ready == 1, "R9", "in_ready in reset", in_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    #1 chk(res_valid == 0, "R9", "valid after reset", res_valid, 0);

    run(24'h3C5A96, 24'h3C5A96, 0, "R1");
    run(24'h123456, 24'h123456 ^ single_flip(0), 1, "R2");
    run(24'hA5A5A5, 24'hA5A5A5 ^ single_flip(4095), 2, "R2");
    run(24'h0F0F0F, 24'h0F0F0F ^ single_flip(2345), 0, "R3");
    run(24'hFFFFFF, 24'h000000, 0, "R5");
    run(24'h00FF00, 24'h00FF01, 1, "R4");
    run(24'h777777, 24'h777777 ^ 24'h0007FF, 0, "R4");
    run(24'hFFFFFF, 24'h000001, 0, "R4");
    run(24'h000000, 24'hFFFFFF, 3, "R4");
    run(24'hFFFFFF, 24'hFFFFFF ^ single_flip(777), 0, "R2");

    for (int i = 0; i < 80; i++) begin
      int sel = int'($urandom % 4);
      int k;
      st = 24'($urandom);
      if (sel == 0)      run(st, st ^ single_flip(int'($urandom % 4096)), int'($urandom % 4), "R2");
      else if (sel == 1) run(st, st, int'($urandom % 4), "R1");
      else begin
        k = int'($urandom % 25);
        run(st, st ^ mask_of(k), int'($urandom % 4), (k == 0) ? "R1" : (k == 12) ? "R2" : "R4");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule